// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller with End-of-Interrupt Handling

This block collects up to eight level-sensitive interrupt request lines and presents a single request to a processor. Each line has three state bits: a mask bit, a pending bit that follows the sampled input, and an in-service bit that records which handlers are running. Priority is fixed, with line 0 the most urgent. A pending, unmasked line raises the processor request only when it outranks every line that is already in service. An interrupt can therefore preempt a running handler of lower urgency, but never one of equal or higher urgency.

When the processor pulses the acknowledge input, the winning line moves from pending to in-service. On the next cycle the block presents an 8-bit vector, built from a programmable 5-bit base and the 3-bit line index. A handler ends in one of three ways: a specific end-of-interrupt command that names a line, a nonspecific command that retires the most urgent line in service, or automatic mode, in which the in-service bit is never kept. The block can also act as the master of a cascade. In that case line 2 carries a slave's request, and an acknowledge won by line 2 drives a 3-bit cascade identifier instead of a vector.

Commands arrive through a single-cycle write port. The port carries a 2-bit opcode, a 3-bit level and an 8-bit data field.

Top module: `prio_intc`

## Requirements
- R1: After reset every mask bit is 1, the pending and in-service bits are 0, and `int_req`, `vec_valid` and `cas_valid` are low. A line whose mask bit is set never raises `int_req`.
- R2: Each clock, the pending bits are loaded from `irq_in`, so a request that drops before acknowledge is no longer pending. `int_req` is high only while some line is both pending and unmasked.
- R3: Among pending, unmasked lines the lowest index wins. `int_req` is high only if that index is lower than the index of every line in service.
- R4: An `ack` pulse while `int_req` is high has these effects. The winner's pending bit clears and its in-service bit sets, unless automatic mode is active. One cycle later `vec_valid` pulses for exactly one cycle, and `vec_out` = {base[4:0], index[2:0]}.
- R5: An `ack` pulse while `int_req` is low leaves the in-service bits unchanged and returns `vec_out` = {base, 3'b111} with `vec_valid` high.
- R6: When `cmd_valid` is high and `cmd_op` = 2'b01, the in-service bit named by `cmd_level` is cleared. If an acknowledge sets the same bit in the same cycle, the set wins.
- R7: When `cmd_valid` is high and `cmd_op` = 2'b10, the in-service bit with the lowest set index is cleared. The command has no effect when no bit is set.
- R8: When `cmd_valid` is high and `cmd_op` = 2'b11, the mode is written: `cmd_data[4:0]` is the vector base, bit 5 requests automatic mode, and bit 6 selects cascade master. Automatic mode takes effect only while bit 6 is also set. While it is in effect, an acknowledge never sets an in-service bit. Reset mode is all zero.
- R9: In cascade-master mode, an acknowledge won by line 2 sets in-service bit 2. One cycle later it pulses `cas_valid` with `cas_id` = 3'd2, and `vec_valid` stays low.
- R10: When `cmd_valid` is high and `cmd_op` = 2'b00, the mask register is loaded from `cmd_data`, where bit i masks line i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 8 | Level-sensitive request lines, bit 0 most urgent |
| cmd_valid | input | 1 | Command write strobe |
| cmd_op | input | 2 | 00 mask, 01 specific EOI, 10 nonspecific EOI, 11 mode |
| cmd_level | input | 3 | Line named by a specific EOI |
| cmd_data | input | 8 | Mask bits or mode fields |
| ack | input | 1 | One-cycle acknowledge from the processor |
| int_req | output | 1 | Request to the processor |
| vec_out | output | 8 | Vector, held until the next acknowledge |
| vec_valid | output | 1 | One-cycle pulse: `vec_out` is fresh |
| cas_id | output | 3 | Cascade identifier of the slave line |
| cas_valid | output | 1 | One-cycle pulse: the slave must supply the vector |

## Verification
The assertions assume that `ack` is a one-cycle pulse. They also assume that no command arrives in a cycle where an assertion compares the in-service bits with their previous value, since a command would change those bits legally. The bench drives every input at the falling edge from a fixed-seed random stream, mixed with directed sequences for preemption, the end-of-interrupt commands, automatic mode, cascading and dropped requests. A bench-side model is built only from the requirements and predicts `int_req`, the vector and the cascade pulse after every rising edge.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  typedef enum logic [1:0] {
    OP_MASK  = 2'b00,
    OP_SEOI  = 2'b01,
    OP_NSEOI = 2'b10,
    OP_MODE  = 2'b11
  } intc_op_e;
endpackage

// File: rtl/intc_first_set.sv
// Fixed-priority finder: lowest set index wins.
module intc_first_set #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_cmd_decode.sv
module intc_cmd_decode
  import prio_intc_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       mask_we,
  output logic       seoi,
  output logic       nseoi,
  output logic       mode_we
);
  intc_op_e op;

  always_comb begin
    op      = intc_op_e'(cmd_op);
    mask_we = cmd_valid && (op == OP_MASK);
    seoi    = cmd_valid && (op == OP_SEOI);
    nseoi   = cmd_valid && (op == OP_NSEOI);
    mode_we = cmd_valid && (op == OP_MODE);
  end
endmodule

// File: rtl/intc_isr_next.sv
// Per-line next state of the in-service register: clear by EOI, then set by acknowledge.
module intc_isr_next #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  isr_q,
  input  logic          seoi,
  input  logic [IW-1:0] seoi_lvl,
  input  logic          nseoi,
  input  logic          ns_found,
  input  logic [IW-1:0] ns_idx,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  output logic [N-1:0]  isr_d
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic clr, set;
    always_comb begin
      clr = (seoi && (seoi_lvl == IW'(g))) ||
            (nseoi && ns_found && (ns_idx == IW'(g)));
      set = set_en && (set_idx == IW'(g));
      isr_d[g] = set || (isr_q[g] && !clr);
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N_LINES   = 8,
  parameter int BASE_W    = 5,
  parameter int CASC_LINE = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_LINES-1:0]           irq_in,
  input  logic                         cmd_valid,
  input  logic [1:0]                   cmd_op,
  input  logic [$clog2(N_LINES)-1:0]   cmd_level,
  input  logic [N_LINES-1:0]           cmd_data,
  input  logic                         ack,
  output logic                         int_req,
  output logic [BASE_W+$clog2(N_LINES)-1:0] vec_out,
  output logic                         vec_valid,
  output logic [$clog2(N_LINES)-1:0]   cas_id,
  output logic                         cas_valid
);
  localparam int IDX_W   = $clog2(N_LINES);
  localparam int VEC_W   = BASE_W + IDX_W;
  localparam int AEOI_B  = BASE_W;
  localparam int MAST_B  = BASE_W + 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_s0, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s  <= rst_s0;
    end
  end

  logic [N_LINES-1:0] mask_q, mask_d, pend_q, pend_d, isr_q, isr_d;
  logic [BASE_W-1:0]  base_q, base_d;
  logic               aeoi_q, aeoi_d, master_q, master_d;
  logic [VEC_W-1:0]   vec_q, vec_d;
  logic               vv_q, vv_d, cv_q, cv_d;
  logic [IDX_W-1:0]   cid_q, cid_d;

  logic mask_we, seoi, nseoi, mode_we;
  intc_cmd_decode u_dec (
    .cmd_valid (cmd_valid), .cmd_op (cmd_op),
    .mask_we (mask_we), .seoi (seoi), .nseoi (nseoi), .mode_we (mode_we)
  );

  logic [IDX_W-1:0] win_idx, isr_idx;
  logic             win_found, isr_found;
  intc_first_set #(.W(N_LINES), .IW(IDX_W)) u_win (
    .vec (pend_q & ~mask_q), .idx (win_idx), .found (win_found)
  );
  intc_first_set #(.W(N_LINES), .IW(IDX_W)) u_isr (
    .vec (isr_q), .idx (isr_idx), .found (isr_found)
  );

  logic grant_ok, aeoi_eff, casc_hit, take;
  always_comb begin
    grant_ok = win_found && (!isr_found || (win_idx < isr_idx));
    aeoi_eff = aeoi_q && master_q;
    casc_hit = master_q && (win_idx == IDX_W'(CASC_LINE));
    take     = ack && grant_ok;
  end

  intc_isr_next #(.N(N_LINES), .IW(IDX_W)) u_isr_nx (
    .isr_q (isr_q), .seoi (seoi), .seoi_lvl (cmd_level),
    .nseoi (nseoi), .ns_found (isr_found), .ns_idx (isr_idx),
    .set_en (take && !aeoi_eff), .set_idx (win_idx), .isr_d (isr_d)
  );

  // next state
  always_comb begin
    pend_d = irq_in;
    if (take) pend_d[win_idx] = 1'b0;
    mask_d   = mask_we ? cmd_data : mask_q;
    base_d   = mode_we ? cmd_data[BASE_W-1:0] : base_q;
    aeoi_d   = mode_we ? cmd_data[AEOI_B] : aeoi_q;
    master_d = mode_we ? cmd_data[MAST_B] : master_q;
    vec_d    = vec_q;
    cid_d    = cid_q;
    vv_d     = 1'b0;
    cv_d     = 1'b0;
    if (ack) begin
      if (take && casc_hit) begin
        cv_d  = 1'b1;
        cid_d = IDX_W'(CASC_LINE);
      end else begin
        vv_d  = 1'b1;
        vec_d = {base_q, (take ? win_idx : {IDX_W{1'b1}})};
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mask_q   <= '1;
      pend_q   <= '0;
      isr_q    <= '0;
      base_q   <= '0;
      aeoi_q   <= 1'b0;
      master_q <= 1'b0;
      vec_q    <= '0;
      cid_q    <= '0;
      vv_q     <= 1'b0;
      cv_q     <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      pend_q   <= pend_d;
      isr_q    <= isr_d;
      base_q   <= base_d;
      aeoi_q   <= aeoi_d;
      master_q <= master_d;
      vec_q    <= vec_d;
      cid_q    <= cid_d;
      vv_q     <= vv_d;
      cv_q     <= cv_d;
    end
  end

  logic unused_data;
  assign unused_data = ^cmd_data;

  assign int_req   = grant_ok;
  assign vec_out   = vec_q;
  assign vec_valid = vv_q;
  assign cas_id    = cid_q;
  assign cas_valid = cv_q;

  // assertions
  assert_req_needs_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_s)
    int_req |-> ((pend_q & ~mask_q) != '0));
  assert_grant_sets_isr_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (ack && int_req && !aeoi_eff) |=> isr_q[$past(win_idx)]);
  assert_pulse_only_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_s)
    !ack |=> (!vec_valid && !cas_valid));
  assert_nseoi_clears_top_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (nseoi && isr_found && !ack) |=> !isr_q[$past(isr_idx)]);
  assert_auto_eoi_keeps_isr_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (ack && aeoi_eff && !cmd_valid) |=> (isr_q == $past(isr_q)));
  assert_one_output_kind_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !(vec_valid && cas_valid));
endmodule

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic [2:0] cmd_level;
  logic [7:0] cmd_data;
  logic       ack;
  logic       int_req, vec_valid, cas_valid;
  logic [7:0] vec_out;
  logic [2:0] cas_id;

  prio_intc dut (
    .clk (clk), .rst_n (rst_n), .irq_in (irq_in), .cmd_valid (cmd_valid),
    .cmd_op (cmd_op), .cmd_level (cmd_level), .cmd_data (cmd_data), .ack (ack),
    .int_req (int_req), .vec_out (vec_out), .vec_valid (vec_valid),
    .cas_id (cas_id), .cas_valid (cas_valid)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [7:0] m_mask, m_pend, m_isr;
  logic [4:0] m_base;
  logic       m_aeoi, m_master;

  function automatic int first_idx(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic m_grant();
    int w = first_idx(m_pend & ~m_mask);
    int i = first_idx(m_isr);
    return (w < 8) && (w < i);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [7:0] irq, logic cv, logic [1:0] op,
                      logic [2:0] lvl, logic [7:0] dat, logic ak);
    int w, i;
    logic ok, aeff, e_vv, e_cv;
    logic [7:0] np, ni, e_vec;
    @(negedge clk);
    irq_in = irq; cmd_valid = cv; cmd_op = op; cmd_level = lvl;
    cmd_data = dat; ack = ak;
    w = first_idx(m_pend & ~m_mask);
    i = first_idx(m_isr);
    ok = (w < 8) && (w < i);
    aeff = m_aeoi && m_master;
    np = irq; ni = m_isr;
    if (cv && op == 2'b01) ni[lvl] = 1'b0;
    if (cv && op == 2'b10 && i < 8) ni[i] = 1'b0;
    if (ak && ok) begin
      np[w] = 1'b0;
      if (!aeff) ni[w] = 1'b1;
    end
    e_cv  = ak && ok && m_master && (w == 2);
    e_vv  = ak && !e_cv;
    e_vec = {m_base, ok ? 3'(w) : 3'd7};
    @(posedge clk);
    #1;
    m_pend = np; m_isr = ni;
    if (cv && op == 2'b00) m_mask = dat;
    if (cv && op == 2'b11) begin
      m_base = dat[4:0]; m_aeoi = dat[5]; m_master = dat[6];
    end
    chk(tag, "int_req", 32'(int_req), 32'(m_grant()));
    chk(tag, "vec_valid", 32'(vec_valid), 32'(e_vv));
    chk(tag, "cas_valid", 32'(cas_valid), 32'(e_cv));
    if (e_vv) chk(tag, "vec_out", 32'(vec_out), 32'(e_vec));
    if (e_cv) chk(tag, "cas_id", 32'(cas_id), 32'd2);
  endtask

  task automatic idle(string tag, logic [7:0] irq);
    step(tag, irq, 1'b0, 2'b00, 3'd0, 8'h00, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; irq_in = '0; cmd_valid = 0; cmd_op = 0; cmd_level = 0;
    cmd_data = 0; ack = 0;
    m_mask = 8'hFF; m_pend = 0; m_isr = 0; m_base = 0; m_aeoi = 0; m_master = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "int_req", 32'(int_req), 0);
    chk("R1", "vec_valid", 32'(vec_valid), 0);
    chk("R1", "cas_valid", 32'(cas_valid), 0);
    idle("R1_masked", 8'hFF);
    idle("R1_masked", 8'hFF);
    // R10 open mask
    step("R10", 8'h00, 1, 2'b00, 0, 8'h00, 0);
    idle("R2", 8'h28);
    idle("R3", 8'h28);
    step("R4", 8'h28, 0, 0, 0, 0, 1);        // line 3 in service
    idle("R3_blocked", 8'h20);
    idle("R3_preempt", 8'h22);
    step("R4_nested", 8'h22, 0, 0, 0, 0, 1);  // line 1 in service
    step("R7", 8'h20, 1, 2'b10, 0, 0, 0);     // clears line 1
    step("R6", 8'h20, 1, 2'b01, 3'd3, 0, 0);  // clears line 3
    step("R4_low", 8'h20, 0, 0, 0, 0, 1);
    step("R7_empty", 8'h00, 1, 2'b10, 0, 0, 0); // clears line 5
    step("R7_empty", 8'h00, 1, 2'b10, 0, 0, 0);
    step("R5", 8'h00, 0, 0, 0, 0, 1);
    // R2 request dropped before acknowledge
    idle("R2_drop", 8'h10);
    idle("R2_drop", 8'h00);
    step("R5_drop", 8'h00, 0, 0, 0, 0, 1);
    // R10 partial mask
    step("R10_mask", 8'h03, 1, 2'b00, 0, 8'h01, 0);
    step("R10_mask", 8'h03, 0, 0, 0, 0, 1);
    step("R6_same_cycle", 8'h00, 1, 2'b01, 3'd1, 0, 1);
    step("R6", 8'h00, 1, 2'b01, 3'd1, 0, 0);
    // R8 automatic mode without master: ignored
    step("R8_base", 8'h00, 1, 2'b11, 0, 8'h31, 0);
    idle("R8", 8'h08);
    step("R8_not_master", 8'h08, 0, 0, 0, 0, 1);
    step("R6", 8'h00, 1, 2'b01, 3'd3, 0, 0);
    // R8 automatic mode as master
    step("R8_master", 8'h00, 1, 2'b11, 0, 8'h6A, 0);
    step("R10", 8'h00, 1, 2'b00, 0, 8'h00, 0);
    idle("R8", 8'h80);
    step("R8_auto", 8'h80, 0, 0, 0, 0, 1);
    idle("R8_auto", 8'h40);
    step("R8_auto", 8'h40, 0, 0, 0, 0, 1);
    // R9 cascade
    step("R9_mode", 8'h00, 1, 2'b11, 0, 8'h47, 0);
    idle("R9", 8'h04);
    step("R9", 8'h04, 0, 0, 0, 0, 1);
    idle("R9_isr", 8'h08);
    step("R9_eoi", 8'h08, 1, 2'b01, 3'd2, 0, 0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] r_irq, r_dat;
      logic r_cv, r_ak;
      logic [1:0] r_op;
      r_irq = 8'($urandom) & 8'($urandom);
      r_cv  = ($urandom % 4) == 0;
      r_op  = 2'($urandom);
      r_dat = 8'($urandom);
      if (r_op == 2'b00) r_dat = r_dat & 8'($urandom);
      r_ak  = ($urandom % 3) == 0;
      step("R3_rand", r_irq, r_cv, r_op, 3'($urandom), r_dat, r_ak);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule